// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the exact unsigned product of two 32-bit operands with a single 32-bit adder, one bit of the multiplier at a time. A one-cycle pulse on `start` latches the multiplicand into its own register. The same edge loads a 64-bit accumulation register with zeros in its upper half and the multiplier in its lower half.

Each following clock cycle is one iteration. The iteration looks at the accumulator's least significant bit. When that bit is set, it adds the multiplicand into the upper half. It then shifts the whole register right by one place. The adder's carry-out enters at the top during that shift, so no product bit is lost.

After the last iteration the controller raises `done` and holds the result. The full register is always visible on `product`. The carry of the most recent iteration is visible on `ovf`. A new `start` after completion begins the next operation. A `start` while an operation is in progress has no effect.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active-low), the block goes idle with `done` = 0, `product` = 0 and `ovf` = 0.
- R2: A `start` = 1 sampled while not running loads `product` to {32'h0, multiplier} and clears `ovf` at that same edge.
- R3: When `done` rises, `product` equals the exact 64-bit unsigned product multiplicand × multiplier, for all operand values including the all-ones extremes.
- R4: Counting the edge that samples `start` as edge 1, `done` is 0 after edges 1 through 32 and becomes 1 at edge 33.
- R5: Once `done` is 1 it stays 1, and `product` and `ovf` stay unchanged, until a new `start` is sampled.
- R6: A `start` sampled while the 32 iterations are in progress changes neither the operands nor the result nor the completion time.
- R7: A `start` sampled while `done` is 1 clears `done` at that edge and runs a full new operation on the new operands.
- R8: `ovf` holds the adder carry-out of the latest iteration. When `done` is 1, it therefore equals `product[63]`.
- R9: Driving `rst_n` low during an operation aborts it. After that edge `done` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (honoured when not running) |
| multiplicand | input | 32 | Multiplicand operand, latched on start |
| multiplier | input | 32 | Multiplier operand, loaded into the low half on start |
| product | output | 64 | Accumulation register; the product once done is 1 |
| ovf | output | 1 | Adder carry-out of the most recent iteration |
| done | output | 1 | High from completion until the next accepted start |

## Verification
An iteration counter that is off by one shows up at once at the ports. `done` rises one edge early or late, and the result is a factor of two wrong or loses a multiplier bit. The bench therefore samples `done` on both sides of edge 33.

A lost carry into bit 63 only appears when the partial sum exceeds 32 bits. The all-ones operand cases expose it, both in the high word of the product and in the `ovf` flag.

A controller that accepts a `start` while it is running would show its damage at the next completion. The result would belong to the intruding operands, or `done` would arrive late.

// File: rtl/shmul_pkg.sv
// Shared types for the shift-add multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package shmul_pkg;

    // Controller phases: waiting, iterating, result held.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } shmul_state_e;

endpackage

// File: rtl/shmul_adder.sv
// Ripple-carry unsigned adder built bit by bit for minimum area.
// Assumes: W >= 1; no carry input; carry-out reported separately.
module shmul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] carry;

    assign carry[0] = 1'b0;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end

    assign cout = carry[W];

endmodule

// File: rtl/shmul_ctrl.sv
// Iteration controller: accepts start when not running, counts ITER
// single-cycle iterations, then holds done until the next start.
// Assumes: ITER >= 2; start may be held or pulsed, it is only honoured
// outside the running phase.
module shmul_ctrl
    import shmul_pkg::*;
#(
    parameter int ITER = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic done
);

    localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    shmul_state_e state_q;
    logic [CW-1:0] cnt_q;

    // Next phase and iteration count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_HOLD: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_HOLD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Decode the datapath strobes and the completion flag.
    always_comb begin
        load = start && (state_q != ST_RUN);
        step = (state_q == ST_RUN);
        done = (state_q == ST_HOLD);
    end

    // R4: completion only follows the final iteration.
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == ST_RUN && $past(cnt_q) == LAST));

    // R6: a start cannot cut an iteration sequence short.
    a_r6_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

    // R7: a start while holding leaves the hold phase.
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && state_q == ST_RUN && cnt_q == '0));

    // R1: reset always returns to idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE && !done));

endmodule

// File: rtl/shmul_datapath.sv
// Operand and accumulation registers around one W-bit adder. On load
// the multiplicand is latched and the accumulator becomes {0, multiplier}.
// Each step conditionally adds into the upper half and shifts right,
// with the carry entering the top bit.
// Assumes: load and step are never both high.
module shmul_datapath #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] acc,
    output logic           carry_flag
);

    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] acc_q;
    logic          carry_q;
    logic [W-1:0]  addend;
    logic [W-1:0]  sum;
    logic          cout;

    // Gate the multiplicand by the bit under test.
    always_comb begin
        addend = acc_q[0] ? mcand_q : '0;
    end

    shmul_adder #(.W(W)) adder_i (
        .a    (acc_q[PW-1:W]),
        .b    (addend),
        .sum  (sum),
        .cout (cout)
    );

    // Register update: load operands or perform one add-and-shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc_q   <= {{W{1'b0}}, mplier_in};
            carry_q <= 1'b0;
        end else if (step) begin
            acc_q   <= {cout, sum, acc_q[W-1:1]};
            carry_q <= cout;
        end
    end

    assign acc        = acc_q;
    assign carry_flag = carry_q;

    // R2: load places the multiplier low and zeros high.
    a_r2_load_layout: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q[PW-1:W] == '0 && acc_q[W-1:0] == $past(mplier_in) && !carry_q));

    // R3: each step moves the low half right by one place.
    a_r3_low_shift: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acc_q[W-2:0] == $past(acc_q[W-1:1])));

    // R5: with no strobe the registers keep their contents.
    a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(acc_q) && $stable(carry_q)));

endmodule

// File: rtl/shift_add_mult.sv
// Top level of the sequential unsigned multiplier: controller plus
// datapath. The result appears after W iterations following the load.
// Assumes: a single clock; synchronous active-low reset.
module shift_add_mult #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic [2*W-1:0] product,
    output logic           ovf,
    output logic           done
);

    logic load;
    logic step;

    shmul_ctrl #(.ITER(W)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    shmul_datapath #(.W(W)) dp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .mcand_in   (multiplicand),
        .mplier_in  (multiplier),
        .acc        (product),
        .carry_flag (ovf)
    );

    // R8: the flag agrees with the top product bit once complete.
    a_r8_ovf_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ovf == product[2*W-1]));

    // R5: a held result stays until a start is sampled.
    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    // R9: reset clears the visible result.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!done && product == '0 && !ovf));

endmodule

// File: tb/shift_add_mult_tb_top.sv
// Directed bench for shift_add_mult: one task per scenario.
module shift_add_mult_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mcand = '0;
    logic [31:0] mplier = '0;
    logic [63:0] product;
    logic        ovf;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    shift_add_mult #(.W(32)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (mcand),
        .multiplier   (mplier),
        .product      (product),
        .ovf          (ovf),
        .done         (done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse start with operands; returns after the start edge (edge 1).
    task automatic kick(input logic [31:0] a, input logic [31:0] b);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    // Full operation with timing, load and result checks.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] exp;
        exp = {32'h0, a} * {32'h0, b};
        kick(a, b);
        chk("R2 load layout", product, {32'h0, b});
        chk("R2 ovf cleared", {63'h0, ovf}, 64'h0);
        wait_neg(31);
        chk("R4 done low after edge 32", {63'h0, done}, 64'h0);
        wait_neg(1);
        chk("R4 done high at edge 33", {63'h0, done}, 64'h1);
        chk("R3 product", product, exp);
        chk("R8 ovf equals bit 63", {63'h0, ovf}, {63'h0, exp[63]});
    endtask

    task automatic t_reset;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        chk("R1 done after reset", {63'h0, done}, 64'h0);
        chk("R1 product after reset", product, 64'h0);
        chk("R1 ovf after reset", {63'h0, ovf}, 64'h0);
    endtask

    task automatic t_products;
        run_op(32'd6, 32'd7);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R8 carry seen on all-ones", {63'h0, ovf}, 64'h1);
        run_op(32'h0, 32'hDEAD_BEEF);
        run_op(32'h1234_5678, 32'h1);
        run_op(32'h8000_0000, 32'h8000_0001);
        run_op(32'hA5A5_1234, 32'h0F0F_F00D);
    endtask

    task automatic t_hold;
        logic [63:0] exp;
        exp = 64'd21 * 64'd3;
        run_op(32'd21, 32'd3);
        mcand  = 32'hFFFF_0000;
        mplier = 32'h0000_FFFF;
        wait_neg(10);
        chk("R5 done held", {63'h0, done}, 64'h1);
        chk("R5 product held", product, exp);
    endtask

    task automatic t_busy_start;
        logic [63:0] exp;
        exp = 64'd1000 * 64'd999;
        kick(32'd1000, 32'd999);
        wait_neg(9);
        kick(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wait_neg(21);
        chk("R6 done not early", {63'h0, done}, 64'h0);
        wait_neg(1);
        chk("R6 done on original schedule", {63'h0, done}, 64'h1);
        chk("R6 original result kept", product, exp);
    endtask

    task automatic t_restart;
        run_op(32'd5, 32'd9);
        kick(32'd11, 32'd13);
        chk("R7 done cleared by restart", {63'h0, done}, 64'h0);
        wait_neg(32);
        chk("R7 restart completes", {63'h0, done}, 64'h1);
        chk("R7 restart result", product, 64'd143);
    endtask

    task automatic t_abort;
        kick(32'hFFFF_FFFF, 32'h7777_7777);
        wait_neg(12);
        rst_n = 1'b0;
        wait_neg(1);
        chk("R9 done after abort", {63'h0, done}, 64'h0);
        chk("R9 product after abort", product, 64'h0);
        rst_n = 1'b1;
        wait_neg(40);
        chk("R9 stays idle", {63'h0, done}, 64'h0);
    endtask

    initial begin
        t_reset();
        t_products();
        t_hold();
        t_busy_start();
        t_restart();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule